// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

The block is a wide synchronous binary up-counter built from identical 4-bit slices. Every slice can be cleared, preset from a data word, advanced by one, or left unchanged. Each of these actions takes place only on the rising clock edge. Each slice has two count enables. The parallel-side enable goes to every slice. The carry-side enable gates both the counting and a combinational terminal-count flag. A parameterised top chains the slices so that the flag of each slice drives the carry-side enable of the slice above it. A higher slice therefore advances only while every slice below it holds all ones, and no ripple carry passes through the count registers.

In each slice the enables and controls are decoded into one of four named operating states: OP_CLEAR, OP_LOAD, OP_COUNT and OP_HOLD. The decode is redone on every edge, with clear taking priority over load and load taking priority over count. The transitions are CLEAR_WINS (clear low, whatever the other inputs), LOAD_WINS (clear high and load low), ADVANCE (clear and load high with both enables high) and STALL (clear and load high with either enable low). A user can shorten the count cycle by decoding a chosen count value outside the block and driving the result into the clear input. The counter then has K states, where the decoded value is K-1.

Top module: `casc_counter`

## Requirements
- R1: When clr_n is low at a rising edge, count_out becomes all zeros, whatever the levels of load_n, cnt_en and carry_in.
- R2: When clr_n is high and load_n is low at a rising edge, count_out takes the value of data_in, whatever the levels of cnt_en and carry_in.
- R3: When clr_n, load_n, cnt_en and carry_in are all high at a rising edge, count_out increases by one. From all ones it wraps to all zeros.
- R4: When clr_n and load_n are high and either cnt_en or carry_in is low at a rising edge, count_out keeps its value.
- R5: carry_out is high exactly when carry_in is high and count_out is all ones. It is combinational and follows carry_in with no clock edge. cnt_en has no effect on it.
- R6: Slices are chained through their terminal counts. A 4-bit slice above bit 3 changes under count conditions only when all the bits below it are ones, so the whole chain behaves as one CNT_W-bit binary counter.
- R7: When clr_n is driven low by an external decode of count value K-1, the counter steps through 0 to K-1 and returns to 0 on the edge that follows the decode.
- R8: No input acts asynchronously. Changes to clr_n, load_n or data_in between edges leave count_out unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Active-low synchronous clear, highest priority |
| load_n | input | 1 | Active-low synchronous parallel load |
| data_in | input | CNT_W | Preset value loaded when load_n is low |
| cnt_en | input | 1 | Parallel-side count enable, shared by all slices |
| carry_in | input | 1 | Carry-side count enable of the lowest slice; also gates carry_out |
| count_out | output | CNT_W | Current count |
| carry_out | output | 1 | Terminal count of the top slice |

## Verification
On every clocked cycle the assertions check the priority among clear, load, count and hold, as well as increment-by-one with wrap. They also check that carry_out matches carry_in ANDed with an all-ones count, and that each upper slice stays still unless the bits below it are all ones. Some behaviour needs a sequence of stimulus and so only the bench scenarios can show it. This covers the modulo-K cycle produced by feeding the decode back into the clear input, and the fact that inputs switched between edges have no effect. It also covers the combinational response of carry_out to carry_in in the middle of a cycle, and a long random run compared against a reference model.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2,
        OP_HOLD  = 2'd3
    } slice_op_e;
endpackage

// File: rtl/ctr_mode_dec.sv
module ctr_mode_dec
    import ctr_pkg::*;
(
    input  logic      clr_n,
    input  logic      load_n,
    input  logic      en_p,
    input  logic      en_t,
    output slice_op_e op
);
    // Priority: clear, then load, then count; otherwise stall.
    always_comb begin
        if (!clr_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (en_p && en_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/ctr_slice.sv
module ctr_slice
    import ctr_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               en_p,
    input  logic               en_t,
    input  logic [SLICE_W-1:0] d,
    output logic [SLICE_W-1:0] q,
    output logic               tc
);
    slice_op_e          op;
    logic [SLICE_W-1:0] q_r;
    logic [SLICE_W-1:0] q_nxt;

    ctr_mode_dec u_dec (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    always_comb begin
        unique case (op)
            OP_CLEAR: q_nxt = '0;
            OP_LOAD:  q_nxt = d;
            OP_COUNT: q_nxt = q_r + 1'b1;
            OP_HOLD:  q_nxt = q_r;
            default:  q_nxt = q_r;
        endcase
    end

    always_ff @(posedge clk) begin
        q_r <= q_nxt;
    end

    // Outputs: terminal count is gated by the carry-side enable only.
    always_comb begin
        q  = q_r;
        tc = en_t & (&q_r);
    end
endmodule

// File: rtl/casc_counter.sv
module casc_counter #(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 3,
    localparam int CNT_W     = SLICE_W * NUM_SLICES
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [CNT_W-1:0] data_in,
    input  logic             cnt_en,
    input  logic             carry_in,
    output logic [CNT_W-1:0] count_out,
    output logic             carry_out
);
    logic [NUM_SLICES:0] chain;

    assign chain[0] = carry_in;

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        ctr_slice #(.SLICE_W(SLICE_W)) u_slice (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .en_p   (cnt_en),
            .en_t   (chain[k]),
            .d      (data_in[k*SLICE_W +: SLICE_W]),
            .q      (count_out[k*SLICE_W +: SLICE_W]),
            .tc     (chain[k+1])
        );
    end

    assign carry_out = chain[NUM_SLICES];
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 3,
    localparam int CNT_W     = SLICE_W * NUM_SLICES
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic [CNT_W-1:0] data_in,
    input logic             cnt_en,
    input logic             carry_in,
    input logic [CNT_W-1:0] count_out,
    input logic             carry_out
);
    // The counter has no reset pin; checks start once a clear or load has set every bit.
    logic primed;
    always_ff @(posedge clk) begin
        if (!clr_n || !load_n)
            primed <= 1'b1;
    end

    p_clear_r1: assert property (@(posedge clk) disable iff (primed !== 1'b1)
        !clr_n |=> count_out == '0);

    p_load_r2: assert property (@(posedge clk) disable iff (primed !== 1'b1)
        (clr_n && !load_n) |=> count_out == $past(data_in));

    p_count_r3: assert property (@(posedge clk) disable iff (primed !== 1'b1)
        (clr_n && load_n && cnt_en && carry_in) |=> count_out == CNT_W'($past(count_out) + 1));

    p_hold_r4: assert property (@(posedge clk) disable iff (primed !== 1'b1)
        (clr_n && load_n && !(cnt_en && carry_in)) |=> $stable(count_out));

    p_tc_r5: assert property (@(posedge clk) disable iff (primed !== 1'b1)
        carry_out == (carry_in && (&count_out)));

    for (genvar k = 1; k < NUM_SLICES; k++) begin : g_casc
        p_upper_still_r6: assert property (@(posedge clk) disable iff (primed !== 1'b1)
            (clr_n && load_n && !(&count_out[k*SLICE_W-1:0]))
            |=> $stable(count_out[k*SLICE_W +: SLICE_W]));
    end
endmodule

bind casc_counter casc_counter_chk #(
    .SLICE_W    (SLICE_W),
    .NUM_SLICES (NUM_SLICES)
) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .data_in   (data_in),
    .cnt_en    (cnt_en),
    .carry_in  (carry_in),
    .count_out (count_out),
    .carry_out (carry_out)
);

// File: tb/sim_casc_counter.sv
`timescale 1ns/1ps
module sim_casc_counter;
    localparam int SW = 4;
    localparam int NS = 3;
    localparam int W  = SW * NS;

    logic         clk = 1'b0;
    logic         clr_n, load_n, cnt_en, carry_in;
    logic [W-1:0] data_in;
    logic [W-1:0] count_out;
    logic         carry_out;
    logic [W-1:0] expv;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    casc_counter #(.SLICE_W(SW), .NUM_SLICES(NS)) u0 (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(data_in),
        .cnt_en(cnt_en), .carry_in(carry_in),
        .count_out(count_out), .carry_out(carry_out)
    );

    function automatic logic [W-1:0] model(logic [W-1:0] q, logic c, logic l,
                                           logic [W-1:0] d, logic p, logic t);
        if (!c)          return '0;
        else if (!l)     return d;
        else if (p && t) return q + 1'b1;
        else             return q;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Inputs are driven after a falling edge; one rising edge, then sample at the falling edge.
    task automatic tick();
        expv = model(expv, clr_n, load_n, data_in, cnt_en, carry_in);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(logic c, logic l, logic [W-1:0] d, logic p, logic t);
        clr_n = c; load_n = l; data_in = d; cnt_en = p; carry_in = t;
    endtask

    task automatic t_reset();
        drive(0, 1, '0, 1, 1);
        tick(); tick();
        chk("R1 reset state", count_out, '0);
        chk("R5 tc at zero", W'(carry_out), '0);
    endtask

    task automatic t_clear();
        drive(1, 0, 12'h5A3, 0, 0); tick();
        chk("R2 preload", count_out, 12'h5A3);
        drive(0, 0, 12'hFFF, 1, 1); tick();
        chk("R1 clear beats load and count", count_out, '0);
    endtask

    task automatic t_load();
        drive(1, 0, 12'hABC, 0, 0); tick();
        chk("R2 load enables low", count_out, 12'hABC);
        drive(1, 0, 12'h123, 1, 1); tick();
        chk("R2 load beats count", count_out, 12'h123);
    endtask

    task automatic t_count();
        drive(1, 1, 12'h000, 1, 1);
        for (int i = 1; i <= 5; i++) begin
            tick();
            chk("R3 increment", count_out, W'(12'h123 + i));
        end
        drive(1, 0, 12'hFFF, 0, 1); tick();
        chk("R5 tc at all ones", W'(carry_out), W'(1));
        drive(1, 1, 12'h000, 1, 1); tick();
        chk("R3 wrap to zero", count_out, '0);
    endtask

    task automatic t_hold();
        drive(1, 0, 12'h7F3, 0, 0); tick();
        drive(1, 1, 12'h000, 0, 1); tick(); tick();
        chk("R4 hold cnt_en low", count_out, 12'h7F3);
        drive(1, 1, 12'h000, 1, 0); tick();
        chk("R4 hold carry_in low", count_out, 12'h7F3);
    endtask

    task automatic t_tc();
        drive(1, 0, 12'hFFF, 0, 0); tick();
        chk("R5 tc low when carry_in low", W'(carry_out), '0);
        #1 carry_in = 1'b1;
        #0.5;
        chk("R5 tc follows carry_in without edge", W'(carry_out), W'(1));
        chk("R4 count unchanged mid cycle", count_out, 12'hFFF);
        load_n = 1'b1; cnt_en = 1'b0; carry_in = 1'b1;
        @(negedge clk); expv = 12'hFFF;
        chk("R5 cnt_en does not gate tc", W'(carry_out), W'(1));
    endtask

    task automatic t_cascade();
        drive(1, 0, 12'h0FE, 0, 0); tick();
        drive(1, 1, 12'h000, 1, 1); tick();
        chk("R6 lower slices fill", count_out, 12'h0FF);
        chk("R6 tc needs top slice", W'(carry_out), '0);
        tick();
        chk("R6 carry into slice 2", count_out, 12'h100);
        drive(1, 0, 12'hEFF, 0, 0); tick();
        drive(1, 1, 12'h000, 1, 1); tick();
        chk("R6 carry into top slice", count_out, 12'hF00);
    endtask

    task automatic t_modk();
        localparam int K = 10;
        drive(0, 1, '0, 1, 1); tick();
        for (int i = 1; i <= 2 * K + 3; i++) begin
            clr_n = (count_out != W'(K - 1));
            tick();
            chk("R7 modulo-K sequence", count_out, W'(i % K));
        end
    endtask

    task automatic t_async();
        drive(1, 0, 12'h444, 0, 0); tick();
        drive(1, 1, 12'h000, 1, 1);
        #0.5 clr_n = 1'b0;
        #0.5 chk("R8 clear waits for edge", count_out, 12'h444);
        load_n = 1'b0; data_in = 12'h999; clr_n = 1'b1;
        #0.5 chk("R8 load waits for edge", count_out, 12'h444);
        load_n = 1'b1;
        tick();
        chk("R8 only edge-time inputs act", count_out, 12'h445);
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            drive(($urandom % 16) != 0, ($urandom % 8) != 0, W'($urandom),
                  ($urandom % 4) != 0, ($urandom % 4) != 0);
            tick();
            chk("R6 random vs model", count_out, expv);
            chk("R5 random tc", W'(carry_out), W'(carry_in && (&expv)));
        end
    endtask

    initial begin
        expv = '0;
        drive(0, 1, '0, 0, 0);
        @(negedge clk);
        t_reset();
        t_clear();
        t_load();
        t_count();
        t_hold();
        t_tc();
        t_cascade();
        t_modk();
        t_async();
        t_random();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule